// File: doc/BRIEF.md
# Transfer Retry Error Counter

This block decides, for each endpoint of a host-side transfer engine, whether a failed transfer attempt should be tried again or should end the transfer with an error completion. Software programs a 2-bit retry allowance per endpoint. When the engine begins a transfer on an endpoint, the block copies that allowance into a working counter. The engine then reports each attempt as either a success or a transaction error.

On a transaction error the counter counts down. The block asks for another attempt until the counter steps from one to zero. At that point it issues a one-cycle error report carrying a transaction-error status code. A programmed allowance of zero selects unlimited retries: the counter stays at zero and no error is ever reported. A success ends the transfer quietly, whatever count is left. The completion logic downstream uses the retry and error pulses to schedule a new attempt or to build the completion event.

Top module: `retry_err_ctl`

## Requirements
- R1: After reset every endpoint's programmed allowance is 0 and no transfer is active, so attempts reported before any start produce neither a retry nor an error; both output strobes are low and err_code is 0.
- R2: With an allowance of 3, a transfer that keeps failing is retried after its first and second failures, and the third failure produces the error report with no retry.
- R3: With an allowance of 1, the first failure produces the error report and no retry.
- R4: With an allowance of 0, every failure produces a retry, the counter does not move, and no error is ever reported.
- R5: With an allowance of 2, the first failure produces a retry and the second produces the error report.
- R6: A successful attempt produces neither strobe and ends the transfer, so a later failure on that endpoint is ignored until the next start.
- R7: Each result appears in the cycle after the attempt is sampled and lasts one cycle. retry_ep or err_ep names the endpoint. err_code is 4 (transaction error) while err_valid is high and 0 otherwise. The two strobes are never high together.
- R8: Endpoints count independently. Attempts on one endpoint never change another endpoint's count.
- R9: A start on an endpoint whose transfer is still active reloads the full programmed allowance.
- R10: Reprogramming an endpoint's allowance leaves the running transfer's count unchanged. The new value applies from the next start.
- R11: After an error report the endpoint is idle, and further failures on it are ignored until the next start.
- R12: When a start and an attempt name the same endpoint in the same cycle, the attempt is ignored and the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for a programmed allowance |
| cfg_ep | input | EP_W | Endpoint being programmed |
| cfg_cnt | input | 2 | Allowance value (0 = unlimited) |
| xfer_start | input | 1 | New transfer begins on xfer_ep |
| xfer_ep | input | EP_W | Endpoint of the new transfer |
| att_valid | input | 1 | An attempt outcome is reported |
| att_ep | input | EP_W | Endpoint of the attempt |
| att_ok | input | 1 | 1 = success, 0 = transaction error |
| retry_valid | output | 1 | One-cycle request to attempt again |
| retry_ep | output | EP_W | Endpoint to retry |
| err_valid | output | 1 | One-cycle error report |
| err_ep | output | EP_W | Endpoint that failed |
| err_code | output | 3 | Status code, 4 while err_valid is high |

## Verification
Each attempt, start or programming write is sampled on one rising edge. Any retry or error result is registered once and is visible for exactly the following cycle, so every result is due one cycle after its stimulus. The bench drives inputs on falling edges and queues one expected result per driven cycle, computed from a behavioural model of the requirements. A monitor samples the outputs shortly after each rising edge and pops one entry, so every cycle is compared, including idle cycles where both strobes must be low.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CNT_W = 2;
  localparam int CC_W  = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [CC_W-1:0] {
    CC_NONE    = 3'd0,
    CC_TXN_ERR = 3'd4
  } cc_e;
endpackage

// File: rtl/rtc_cfg_bank.sv
module rtc_cfg_bank
  import rtc_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [EP_W-1:0]         wr_ep,
  input  cnt_t                    wr_cnt,
  output logic [NUM_EP*CNT_W-1:0] prog_flat
);
  cnt_t prog_q [NUM_EP];
  cnt_t prog_d [NUM_EP];
  logic [NUM_EP-1:0] en;

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      en[i]     = we && (wr_ep == EP_W'(i));
      prog_d[i] = wr_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_EP; i++) prog_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_EP; i++)
        if (en[i]) prog_q[i] <= prog_d[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_EP; i++)
      prog_flat[i*CNT_W +: CNT_W] = prog_q[i];
  end
endmodule

// File: rtl/rtc_ep_slice.sv
module rtc_ep_slice
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cnt_t load_val,
  input  logic hit,
  input  logic ok,
  output logic active_o,
  output cnt_t cnt_o,
  output logic retry_o,
  output logic fail_o
);
  logic act_q, act_d;
  cnt_t cnt_q, cnt_d;
  logic live_fail;
  logic last_try;
  logic en;

  assign live_fail = hit && act_q && !ok;
  assign last_try  = (cnt_q == cnt_t'(1));
  assign retry_o   = live_fail && !last_try;
  assign fail_o    = live_fail && last_try;
  assign en        = start || (hit && act_q);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = load_val;
    end else if (hit && act_q) begin
      if (ok) begin
        act_d = 1'b0;
      end else if (last_try) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - cnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = act_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/rtc_report.sv
module rtc_report
  import rtc_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] retry_vec,
  input  logic [NUM_EP-1:0] fail_vec,
  output logic              retry_valid,
  output logic [EP_W-1:0]   retry_ep,
  output logic              err_valid,
  output logic [EP_W-1:0]   err_ep,
  output logic [CC_W-1:0]   err_code
);
  logic [EP_W-1:0] r_idx, f_idx;
  logic            rv_d, ev_d;
  cc_e             code_d;
  logic            rv_q, ev_q;
  logic [EP_W-1:0] rep_q, eep_q;
  cc_e             code_q;

  always_comb begin
    r_idx = '0;
    f_idx = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (retry_vec[i]) r_idx = r_idx | EP_W'(i);
      if (fail_vec[i])  f_idx = f_idx | EP_W'(i);
    end
    rv_d   = |retry_vec;
    ev_d   = |fail_vec;
    code_d = ev_d ? CC_TXN_ERR : CC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      ev_q   <= 1'b0;
      rep_q  <= '0;
      eep_q  <= '0;
      code_q <= CC_NONE;
    end else begin
      rv_q   <= rv_d;
      ev_q   <= ev_d;
      rep_q  <= r_idx;
      eep_q  <= f_idx;
      code_q <= code_d;
    end
  end

  assign retry_valid = rv_q;
  assign retry_ep    = rep_q;
  assign err_valid   = ev_q;
  assign err_ep      = eep_q;
  assign err_code    = code_q;
endmodule

// File: rtl/retry_err_ctl.sv
module retry_err_ctl
  import rtc_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [EP_W-1:0] cfg_ep,
  input  logic [1:0]      cfg_cnt,
  input  logic            xfer_start,
  input  logic [EP_W-1:0] xfer_ep,
  input  logic            att_valid,
  input  logic [EP_W-1:0] att_ep,
  input  logic            att_ok,
  output logic            retry_valid,
  output logic [EP_W-1:0] retry_ep,
  output logic            err_valid,
  output logic [EP_W-1:0] err_ep,
  output logic [2:0]      err_code
);
  logic rst_s0, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_q_n <= rst_s0;
    end
  end

  logic [NUM_EP*CNT_W-1:0] prog_flat;
  logic [NUM_EP*CNT_W-1:0] cnt_flat;
  logic [NUM_EP-1:0]       active_vec;
  logic [NUM_EP-1:0]       start_vec, hit_vec, retry_vec, fail_vec;

  rtc_cfg_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .we        (cfg_we),
    .wr_ep     (cfg_ep),
    .wr_cnt    (cfg_cnt),
    .prog_flat (prog_flat)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    assign start_vec[g] = xfer_start && (xfer_ep == EP_W'(g));
    assign hit_vec[g]   = att_valid && (att_ep == EP_W'(g)) && !start_vec[g];

    rtc_ep_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .start    (start_vec[g]),
      .load_val (prog_flat[g*CNT_W +: CNT_W]),
      .hit      (hit_vec[g]),
      .ok       (att_ok),
      .active_o (active_vec[g]),
      .cnt_o    (cnt_flat[g*CNT_W +: CNT_W]),
      .retry_o  (retry_vec[g]),
      .fail_o   (fail_vec[g])
    );
  end

  rtc_report #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_rep (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .retry_vec   (retry_vec),
    .fail_vec    (fail_vec),
    .retry_valid (retry_valid),
    .retry_ep    (retry_ep),
    .err_valid   (err_valid),
    .err_ep      (err_ep),
    .err_code    (err_code)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 3
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                xfer_start,
  input logic [EP_W-1:0]     xfer_ep,
  input logic                att_valid,
  input logic [EP_W-1:0]     att_ep,
  input logic                att_ok,
  input logic [NUM_EP-1:0]   active_vec,
  input logic [NUM_EP*2-1:0] cnt_flat,
  input logic                retry_valid,
  input logic [EP_W-1:0]     retry_ep,
  input logic                err_valid,
  input logic [EP_W-1:0]     err_ep,
  input logic [2:0]          err_code
);
  logic same_ep;
  logic live_fail;
  logic [1:0] cur_cnt;

  assign same_ep   = xfer_start && (xfer_ep == att_ep);
  assign live_fail = att_valid && !att_ok && active_vec[att_ep] && !same_ep;
  assign cur_cnt   = cnt_flat[att_ep*2 +: 2];

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(retry_valid && err_valid));

  assert_code_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_valid ? (err_code == 3'd4) : (err_code == 3'd0));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_valid |=> !(err_valid && err_ep == $past(err_ep)));

  assert_success_quiet_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (att_valid && att_ok) |=> (!retry_valid && !err_valid));

  assert_idle_ignored_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (att_valid && !active_vec[att_ep]) |=> (!retry_valid && !err_valid));

  assert_start_wins_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (att_valid && same_ep) |=> (!retry_valid && !err_valid));

  assert_unlimited_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live_fail && cur_cnt == 2'd0) |=> (retry_valid && retry_ep == $past(att_ep)));

  assert_terminal_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live_fail && cur_cnt == 2'd1) |=> (err_valid && err_ep == $past(att_ep)));

  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (live_fail && cur_cnt > 2'd1) |=>
      (retry_valid && cnt_flat[$past(att_ep)*2 +: 2] == $past(cur_cnt) - 2'd1));
endmodule

bind retry_err_ctl rtc_checker #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .xfer_start  (xfer_start),
  .xfer_ep     (xfer_ep),
  .att_valid   (att_valid),
  .att_ep      (att_ep),
  .att_ok      (att_ok),
  .active_vec  (active_vec),
  .cnt_flat    (cnt_flat),
  .retry_valid (retry_valid),
  .retry_ep    (retry_ep),
  .err_valid   (err_valid),
  .err_ep      (err_ep),
  .err_code    (err_code)
);

// File: tb/tb_retry_err_ctl.sv
`timescale 1ns/1ps
module tb_retry_err_ctl;
  localparam int NUM_EP = 8;
  localparam int EP_W   = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [EP_W-1:0] cfg_ep;
  logic [1:0]      cfg_cnt;
  logic            xfer_start;
  logic [EP_W-1:0] xfer_ep;
  logic            att_valid;
  logic [EP_W-1:0] att_ep;
  logic            att_ok;
  logic            retry_valid;
  logic [EP_W-1:0] retry_ep;
  logic            err_valid;
  logic [EP_W-1:0] err_ep;
  logic [2:0]      err_code;

  always #2.5 clk = ~clk;

  retry_err_ctl #(.NUM_EP(NUM_EP), .EP_W(EP_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_cnt(cfg_cnt),
    .xfer_start(xfer_start), .xfer_ep(xfer_ep),
    .att_valid(att_valid), .att_ep(att_ep), .att_ok(att_ok),
    .retry_valid(retry_valid), .retry_ep(retry_ep),
    .err_valid(err_valid), .err_ep(err_ep), .err_code(err_code)
  );

  int n_checks = 0;
  int n_errors = 0;

  // expected-result scoreboard
  bit    q_rv[$];
  int    q_rep[$];
  bit    q_ev[$];
  int    q_eep[$];
  string q_tag[$];

  // behavioural model of the requirements
  int m_prog[NUM_EP];
  int m_cnt[NUM_EP];
  bit m_act[NUM_EP];

  task automatic step(input bit we, input int cep, input int cc,
                      input bit st, input int sep,
                      input bit av, input int aep, input bit aok,
                      input string tag);
    bit rv = 0, ev = 0;
    @(negedge clk);
    cfg_we = we; cfg_ep = EP_W'(cep); cfg_cnt = 2'(cc);
    xfer_start = st; xfer_ep = EP_W'(sep);
    att_valid = av; att_ep = EP_W'(aep); att_ok = aok;
    if (av && m_act[aep] && !(st && sep == aep)) begin
      if (aok) m_act[aep] = 0;
      else if (m_cnt[aep] == 0) rv = 1;
      else if (m_cnt[aep] == 1) begin ev = 1; m_act[aep] = 0; m_cnt[aep] = 0; end
      else begin m_cnt[aep]--; rv = 1; end
    end
    if (st) begin m_act[sep] = 1; m_cnt[sep] = m_prog[sep]; end
    if (we) m_prog[cep] = cc;
    q_rv.push_back(rv);  q_rep.push_back(aep);
    q_ev.push_back(ev);  q_eep.push_back(aep);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic load(input int ep, input int c, input string tag);
    step(1, ep, c, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic start(input int ep, input string tag);
    step(0, 0, 0, 1, ep, 0, 0, 0, tag);
  endtask
  task automatic fail(input int ep, input string tag);
    step(0, 0, 0, 0, 0, 1, ep, 0, tag);
  endtask
  task automatic pass(input int ep, input string tag);
    step(0, 0, 0, 0, 0, 1, ep, 1, tag);
  endtask

  // monitor: one result due per driven cycle, visible just after the next edge
  always @(posedge clk) begin
    #1;
    if (q_rv.size() > 0) begin
      bit rv; int rep; bit ev; int eep; string tag; bit bad;
      rv = q_rv.pop_front(); rep = q_rep.pop_front();
      ev = q_ev.pop_front(); eep = q_eep.pop_front(); tag = q_tag.pop_front();
      bad = (retry_valid !== rv) || (err_valid !== ev) ||
            (rv && (int'(retry_ep) != rep)) || (ev && (int'(err_ep) != eep)) ||
            (err_code !== (ev ? 3'd4 : 3'd0));
      n_checks++;
      if (bad) begin
        n_errors++;
        $display("FAIL %s: got rv=%0b rep=%0d ev=%0b eep=%0d code=%0d, exp rv=%0b rep=%0d ev=%0b eep=%0d code=%0d",
                 tag, retry_valid, retry_ep, err_valid, err_ep, err_code,
                 rv, rep, ev, eep, ev ? 4 : 0);
      end
    end
  end

  initial begin
    #200000;
    n_errors++;
    $display("FAIL watchdog: got hung run, exp completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_EP; i++) begin m_prog[i] = 0; m_cnt[i] = 0; m_act[i] = 0; end
    rst_n = 1'b0;
    cfg_we = 0; cfg_ep = 0; cfg_cnt = 0; xfer_start = 0; xfer_ep = 0;
    att_valid = 0; att_ep = 0; att_ok = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (retry_valid !== 1'b0 || err_valid !== 1'b0 || err_code !== 3'd0) begin
      n_errors++;
      $display("FAIL R1: got rv=%0b ev=%0b code=%0d, exp 0 0 0", retry_valid, err_valid, err_code);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: nothing active after reset
    fail(0, "R1"); idle("R1"); fail(7, "R1"); idle("R1");

    // R2: allowance 3
    load(1, 3, "R2"); start(1, "R2");
    fail(1, "R2"); fail(1, "R2"); fail(1, "R2 R7");
    fail(1, "R11"); idle("R11");

    // R3: allowance 1
    load(2, 1, "R3"); start(2, "R3"); fail(2, "R3 R7"); fail(2, "R11");

    // R5: allowance 2
    load(3, 2, "R5"); start(3, "R5"); fail(3, "R5"); fail(3, "R5"); idle("R5");

    // R4: unlimited
    load(4, 0, "R4"); start(4, "R4");
    for (int k = 0; k < 10; k++) fail(4, "R4");
    pass(4, "R4 R6"); fail(4, "R6");

    // R6: success part-way ends the transfer
    start(1, "R6"); fail(1, "R6"); pass(1, "R6"); fail(1, "R6"); idle("R6");

    // R8: interleaved endpoints
    start(1, "R8"); start(2, "R8");
    fail(1, "R8"); fail(2, "R8"); fail(1, "R8"); fail(1, "R8"); fail(2, "R8");

    // R9: restart reloads the full allowance
    start(1, "R9"); fail(1, "R9"); fail(1, "R9");
    start(1, "R9"); fail(1, "R9"); fail(1, "R9"); fail(1, "R9");

    // R10: reprogramming during a transfer
    load(5, 2, "R10"); start(5, "R10"); load(5, 1, "R10");
    fail(5, "R10"); fail(5, "R10");
    start(5, "R10"); fail(5, "R10");

    // R12: start and attempt on the same endpoint in one cycle
    load(6, 1, "R12");
    step(0, 0, 0, 1, 6, 1, 6, 0, "R12");
    fail(6, "R12");
    // start on one endpoint while another fails
    start(3, "R8");
    step(0, 0, 0, 1, 7, 1, 3, 0, "R8");
    fail(3, "R8"); fail(7, "R4");

    repeat (3) idle("R7");
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule